// File: doc/BRIEF.md
# Bus-Slave Local-RAM Region Decoder

This block sits behind a serial-bus slave front end that has already reduced bus traffic to a byte address, a write strobe, a read strobe and write data. It sorts each bus access into one of the regions of a 256-byte local RAM. The local RAM is shared with a host CPU. The regions are a direct region (bus read and write), a read-only region (bus read only), a FIFO window, and a CPU-private tail that the bus never reaches. Three programmable base addresses, each in 8-byte steps, set where the regions start. The FIFO is never addressed directly from the bus. Instead, a read of the fixed port address 0x7F produces a pop strobe.

Any bus write that the region rules refuse is dropped and sets a sticky error flag. Accepted writes to the low part of the map raise access-interrupt status bits. There is one bit per byte for addresses 0x00–0x0F. Above that there is one bit per 4-byte group, and a group's bit is raised only by a write to the last byte of the group. The CPU writes the enable, set and clear registers for these bits, and a single interrupt line reports any enabled status bit.

The access sequencer is a state machine with six states:
- `ST_IDLE`: no access is in progress.
- `ST_WR_PASS`: a write has been accepted.
- `ST_RD_PASS`: a RAM read is in progress.
- `ST_POP`: a FIFO pop is in progress.
- `ST_WR_DROP`: a write has been refused.
- `ST_RD_DROP`: a read has been ignored.

Every state moves on at every clock. A bus write goes to `ST_WR_PASS` if its address is in the direct region, and to `ST_WR_DROP` otherwise. A bus read goes to `ST_RD_PASS` for the direct and read-only regions, to `ST_POP` for the port address, and to `ST_RD_DROP` otherwise. With no strobe, the machine returns to `ST_IDLE`.

Top module: `bus_region_decoder`

## Requirements
- R1: After reset, `lram_we`, `lram_re`, `fifo_pop`, `wr_err`, `acc_irq`, `acc_enable` and `acc_status` are all zero.
- R2: With a valid configuration, a bus write to an address below the read-only base gives `lram_we` high for exactly the following cycle, with `lram_addr` and `lram_wdata` equal to the bus address and data.
- R3: A bus read of an address in the direct region, or in the read-only region (read-only base ≤ address < FIFO base, address ≠ 0x7F), gives `lram_re` for the following cycle with the bus address on `lram_addr`, and no write strobe.
- R4: A bus write into the read-only region gives no strobe and sets `wr_err` one cycle after the strobe cycle.
- R5: A bus read of address 0x7F under a valid configuration gives a one-cycle `fifo_pop` and no RAM strobe. A bus write to 0x7F is refused and sets `wr_err`.
- R6: Under a valid configuration, two kinds of address give no strobe on a read and give a refused write that sets `wr_err`. The first is an address between the FIFO base and the RAM base other than 0x7F. The second is an address at or above the RAM base.
- R7: `cfg_valid` is high exactly when all of the following hold:
  - all three bases are multiples of 8;
  - the read-only base and the FIFO base are each ≤ 0x78;
  - the RAM base is ≤ 0x100;
  - read-only base ≤ FIFO base ≤ RAM base.
- R8: While `cfg_valid` is low, every bus access gives no strobe, and every write sets `wr_err`.
- R9: `wr_err` stays set until `err_clr` is high at a clock edge. A refusal and a clear at the same edge leave it set.
- R10: An accepted write to address a (0x00 ≤ a ≤ 0x0F) sets `acc_status` bit 31−a.
- R11: An accepted write to address 0x10+4g+3 (g = 0..15) sets `acc_status` bit 15−g. Writes to other bytes of a group, or to 0x50 and above, set no bit.
- R12: `cpu_set_we` ORs `cpu_wdata` into the status. `cpu_clr_we` clears the status bits where `cpu_wdata` is 1. A bus hit in the same cycle as a clear leaves its bit set.
- R13: `cpu_en_we` loads `cpu_wdata` into `acc_enable`. `acc_irq` is high when any bit of `acc_status` AND `acc_enable` is set.
- R14: When `bus_wr` and `bus_rd` are both high, the access is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ro_base | input | 9 | Read-only region base, bytes |
| fifo_base | input | 9 | FIFO region base, bytes |
| ram_base | input | 9 | CPU-private region base, bytes |
| bus_addr | input | 8 | Bus byte address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Bus write strobe, one cycle |
| bus_rd | input | 1 | Bus read strobe, one cycle |
| err_clr | input | 1 | Clears the sticky write error |
| cpu_wdata | input | 32 | CPU data for enable, set and clear |
| cpu_en_we | input | 1 | Load the enable register |
| cpu_set_we | input | 1 | OR data into the status |
| cpu_clr_we | input | 1 | Clear status bits where data is 1 |
| lram_addr | output | 8 | Local RAM address |
| lram_wdata | output | 8 | Local RAM write data |
| lram_we | output | 1 | Local RAM write strobe |
| lram_re | output | 1 | Local RAM read strobe |
| fifo_pop | output | 1 | FIFO pop strobe |
| cfg_valid | output | 1 | Base configuration is legal |
| wr_err | output | 1 | Sticky refused-write flag |
| acc_enable | output | 32 | Access-interrupt enable register |
| acc_status | output | 32 | Access-interrupt status register |
| acc_irq | output | 1 | Access interrupt |

## Verification
If the sequencer takes the wrong branch, the RAM or pop strobes are wrong in the very next cycle. That cycle is where every access is sampled. A wrong error or status update shows one edge later, on `wr_err` and `acc_status`. Both are compared after every access against a model of the region rules and the uneven bit map. Random configurations include illegal ones. Random mixes of strobes, clears and CPU register writes reach the same-cycle races, and directed cases pin down the region edges and the first and last map bits.

// File: rtl/bsrd_pkg.sv
package bsrd_pkg;

    typedef enum logic [2:0] {
        RG_DIRECT,
        RG_RDONLY,
        RG_FIFOPORT,
        RG_FIFOWIN,
        RG_PRIVATE,
        RG_NONE
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PASS,
        ST_RD_PASS,
        ST_POP,
        ST_WR_DROP,
        ST_RD_DROP
    } acc_state_e;

endpackage

// File: rtl/bsrd_region_map.sv
module bsrd_region_map
    import bsrd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BLK_LOG   = 3,
    parameter int RO_MAX    = 'h78,
    parameter int FIFO_MAX  = 'h78,
    parameter int RAM_MAX   = 'h100,
    parameter int PORT_ADDR = 'h7F
) (
    input  logic [ADDR_W:0]   ro_base,
    input  logic [ADDR_W:0]   fifo_base,
    input  logic [ADDR_W:0]   ram_base,
    input  logic [ADDR_W-1:0] addr,
    output logic              cfg_ok,
    output region_e           region
);
    localparam int BASE_W = ADDR_W + 1;

    logic [BASE_W-1:0] a_ext;
    logic              aligned;
    logic              in_limits;
    logic              ordered;

    assign a_ext     = {1'b0, addr};
    assign aligned   = (ro_base[BLK_LOG-1:0] == '0) && (fifo_base[BLK_LOG-1:0] == '0)
                    && (ram_base[BLK_LOG-1:0] == '0);
    assign in_limits = (ro_base <= BASE_W'(RO_MAX)) && (fifo_base <= BASE_W'(FIFO_MAX))
                    && (ram_base <= BASE_W'(RAM_MAX));
    assign ordered   = (ro_base <= fifo_base) && (fifo_base <= ram_base);
    assign cfg_ok    = aligned && in_limits && ordered;

    always_comb begin
        if (!cfg_ok)                          region = RG_NONE;
        else if (a_ext < ro_base)             region = RG_DIRECT;
        else if (addr == ADDR_W'(PORT_ADDR))  region = RG_FIFOPORT;
        else if (a_ext < fifo_base)           region = RG_RDONLY;
        else if (a_ext < ram_base)            region = RG_FIFOWIN;
        else                                  region = RG_PRIVATE;
    end
endmodule

// File: rtl/bsrd_access_fsm.sv
module bsrd_access_fsm
    import bsrd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  region_e           region,
    input  logic              err_clr,
    output logic [ADDR_W-1:0] lram_addr,
    output logic [DATA_W-1:0] lram_wdata,
    output logic              lram_we,
    output logic              lram_re,
    output logic              fifo_pop,
    output logic              wr_err,
    output logic              hit_valid
);
    acc_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (bus_wr) begin
            state_d = (region == RG_DIRECT) ? ST_WR_PASS : ST_WR_DROP;
        end else if (bus_rd) begin
            unique case (region)
                RG_DIRECT, RG_RDONLY: state_d = ST_RD_PASS;
                RG_FIFOPORT:          state_d = ST_POP;
                default:              state_d = ST_RD_DROP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lram_addr  <= '0;
            lram_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (bus_wr || bus_rd) begin
                lram_addr  <= bus_addr;
                lram_wdata <= bus_wdata;
            end
        end
    end

    always_comb begin
        lram_we   = 1'b0;
        lram_re   = 1'b0;
        fifo_pop  = 1'b0;
        hit_valid = 1'b0;
        unique case (state_q)
            ST_WR_PASS: begin
                lram_we   = 1'b1;
                hit_valid = 1'b1;
            end
            ST_RD_PASS: lram_re  = 1'b1;
            ST_POP:     fifo_pop = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     wr_err <= 1'b0;
        else if (state_q == ST_WR_DROP) wr_err <= 1'b1;
        else if (err_clr)               wr_err <= 1'b0;
    end

    assert_pop_follows_port_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && region == RG_FIFOPORT) |=> (fifo_pop && !lram_re));
    assert_rdonly_write_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && region == RG_RDONLY) |=> !lram_we);
    assert_invalid_cfg_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && region == RG_NONE) |=> !(lram_we || lram_re || fifo_pop));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err && !err_clr) |=> wr_err);
endmodule

// File: rtl/bsrd_acc_irq.sv
module bsrd_acc_irq #(
    parameter int ADDR_W      = 8,
    parameter int BYTE_SLOTS  = 16,
    parameter int GROUP_SLOTS = 16,
    parameter int GROUP_LOG   = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  hit_valid,
    input  logic [ADDR_W-1:0]                     hit_addr,
    input  logic [BYTE_SLOTS+GROUP_SLOTS-1:0]     cpu_wdata,
    input  logic                                  cpu_en_we,
    input  logic                                  cpu_set_we,
    input  logic                                  cpu_clr_we,
    output logic [BYTE_SLOTS+GROUP_SLOTS-1:0]     acc_enable,
    output logic [BYTE_SLOTS+GROUP_SLOTS-1:0]     acc_status,
    output logic                                  acc_irq
);
    localparam int IRQ_W    = BYTE_SLOTS + GROUP_SLOTS;
    localparam int GROUP_SZ = 1 << GROUP_LOG;

    logic [IRQ_W-1:0] hit_mask;
    logic [IRQ_W-1:0] set_mask;
    logic [IRQ_W-1:0] clr_mask;

    for (genvar i = 0; i < BYTE_SLOTS; i++) begin : g_byte_bit
        assign hit_mask[IRQ_W-1-i] = hit_valid && (hit_addr == ADDR_W'(i));
    end

    for (genvar g = 0; g < GROUP_SLOTS; g++) begin : g_group_bit
        assign hit_mask[GROUP_SLOTS-1-g] = hit_valid
            && (hit_addr == ADDR_W'(BYTE_SLOTS + g * GROUP_SZ + GROUP_SZ - 1));
    end

    assign set_mask = cpu_set_we ? cpu_wdata : '0;
    assign clr_mask = cpu_clr_we ? cpu_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_enable <= '0;
            acc_status <= '0;
        end else begin
            if (cpu_en_we) acc_enable <= cpu_wdata;
            acc_status <= (acc_status & ~clr_mask) | set_mask | hit_mask;
        end
    end

    assign acc_irq = |(acc_status & acc_enable);

    assert_set_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_set_we |=> ((acc_status & $past(cpu_wdata)) == $past(cpu_wdata)));
    assert_hit_beats_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_addr == '0) |=> acc_status[IRQ_W-1]);
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
    import bsrd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int BYTE_SLOTS  = 16,
    parameter int GROUP_SLOTS = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W:0]                   ro_base,
    input  logic [ADDR_W:0]                   fifo_base,
    input  logic [ADDR_W:0]                   ram_base,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic                              err_clr,
    input  logic [BYTE_SLOTS+GROUP_SLOTS-1:0] cpu_wdata,
    input  logic                              cpu_en_we,
    input  logic                              cpu_set_we,
    input  logic                              cpu_clr_we,
    output logic [ADDR_W-1:0]                 lram_addr,
    output logic [DATA_W-1:0]                 lram_wdata,
    output logic                              lram_we,
    output logic                              lram_re,
    output logic                              fifo_pop,
    output logic                              cfg_valid,
    output logic                              wr_err,
    output logic [BYTE_SLOTS+GROUP_SLOTS-1:0] acc_enable,
    output logic [BYTE_SLOTS+GROUP_SLOTS-1:0] acc_status,
    output logic                              acc_irq
);
    region_e region;
    logic    hit_valid;

    bsrd_region_map #(.ADDR_W(ADDR_W)) u_map (
        .ro_base   (ro_base),
        .fifo_base (fifo_base),
        .ram_base  (ram_base),
        .addr      (bus_addr),
        .cfg_ok    (cfg_valid),
        .region    (region)
    );

    bsrd_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .region     (region),
        .err_clr    (err_clr),
        .lram_addr  (lram_addr),
        .lram_wdata (lram_wdata),
        .lram_we    (lram_we),
        .lram_re    (lram_re),
        .fifo_pop   (fifo_pop),
        .wr_err     (wr_err),
        .hit_valid  (hit_valid)
    );

    bsrd_acc_irq #(
        .ADDR_W      (ADDR_W),
        .BYTE_SLOTS  (BYTE_SLOTS),
        .GROUP_SLOTS (GROUP_SLOTS),
        .GROUP_LOG   (2)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_valid  (hit_valid),
        .hit_addr   (lram_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_en_we  (cpu_en_we),
        .cpu_set_we (cpu_set_we),
        .cpu_clr_we (cpu_clr_we),
        .acc_enable (acc_enable),
        .acc_status (acc_status),
        .acc_irq    (acc_irq)
    );

    assert_invalid_write_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !cfg_valid) |=> !lram_we);
endmodule

// File: tb/sim_bus_region_decoder.sv
module sim_bus_region_decoder;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [8:0]  ro_base, fifo_base, ram_base;
    logic [7:0]  bus_addr, bus_wdata;
    logic        bus_wr, bus_rd, err_clr;
    logic [31:0] cpu_wdata;
    logic        cpu_en_we, cpu_set_we, cpu_clr_we;
    logic [7:0]  lram_addr, lram_wdata;
    logic        lram_we, lram_re, fifo_pop, cfg_valid, wr_err, acc_irq;
    logic [31:0] acc_enable, acc_status;

    bus_region_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ro_base(ro_base), .fifo_base(fifo_base),
        .ram_base(ram_base), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .err_clr(err_clr), .cpu_wdata(cpu_wdata),
        .cpu_en_we(cpu_en_we), .cpu_set_we(cpu_set_we), .cpu_clr_we(cpu_clr_we),
        .lram_addr(lram_addr), .lram_wdata(lram_wdata), .lram_we(lram_we),
        .lram_re(lram_re), .fifo_pop(fifo_pop), .cfg_valid(cfg_valid),
        .wr_err(wr_err), .acc_enable(acc_enable), .acc_status(acc_status),
        .acc_irq(acc_irq)
    );

    int total = 0;
    int bad   = 0;
    logic [31:0] m_st, m_en;
    logic        m_err;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R7 legality model
    function automatic bit cfg_ok_f(input logic [8:0] ro, input logic [8:0] fi, input logic [8:0] rm);
        return (ro[2:0] == 0) && (fi[2:0] == 0) && (rm[2:0] == 0) && (ro <= 9'h78)
            && (fi <= 9'h78) && (rm <= 9'h100) && (ro <= fi) && (fi <= rm);
    endfunction

    // 0 direct, 1 read-only, 2 fifo port, 3 fifo window, 4 private, 5 invalid cfg
    function automatic int kind_f(input logic [7:0] a);
        if (!cfg_ok_f(ro_base, fifo_base, ram_base)) return 5;
        if ({1'b0, a} < ro_base) return 0;
        if (a == 8'h7F) return 2;
        if ({1'b0, a} < fifo_base) return 1;
        if ({1'b0, a} < ram_base) return 3;
        return 4;
    endfunction

    // R10 / R11 map model
    function automatic logic [31:0] mask_f(input logic [7:0] a);
        if (a < 8'h10) return 32'h1 << (31 - a);
        if (a < 8'h50 && a[1:0] == 2'b11) return 32'h1 << (15 - ((a - 8'h10) >> 2));
        return 32'h0;
    endfunction

    function automatic string tag_f(input int k, input bit wr, input bit rd);
        if (wr && rd) return "R14";
        if (k == 5) return "R8";
        if (k == 2) return "R5";
        if (k >= 3) return "R6";
        if (k == 1) return wr ? "R4" : "R3";
        return wr ? "R2" : "R3";
    endfunction

    task automatic set_cfg(input logic [8:0] ro, input logic [8:0] fi, input logic [8:0] rm);
        @(negedge clk);
        ro_base = ro; fifo_base = fi; ram_base = rm;
        #1;
        chk(cfg_valid == cfg_ok_f(ro, fi, rm), "R7 cfg_valid", cfg_valid, cfg_ok_f(ro, fi, rm));
    endtask

    task automatic access(input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] d,
                          input bit eclr, input logic [31:0] cmask);
        int k;
        bit e_we, e_re, e_pop, drop;
        string t;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        k     = kind_f(a);
        e_we  = wr && k == 0;
        e_re  = !wr && rd && (k == 0 || k == 1);
        e_pop = !wr && rd && k == 2;
        drop  = wr && k != 0;
        t     = tag_f(k, wr, rd);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; err_clr = eclr;
        if (cmask != 0) begin cpu_wdata = cmask; cpu_clr_we = 1'b1; end
        chk({lram_we, lram_re, fifo_pop} == {e_we, e_re, e_pop}, {t, " strobes"},
            {lram_we, lram_re, fifo_pop}, {e_we, e_re, e_pop});
        if (e_we || e_re)
            chk(lram_addr == a && (!e_we || lram_wdata == d), {t, " addr/data"},
                {lram_addr, lram_wdata}, {a, d});
        m_st  = (m_st & ~cmask) | (e_we ? mask_f(a) : 32'h0);
        m_err = drop ? 1'b1 : (eclr ? 1'b0 : m_err);
        @(negedge clk);
        err_clr = 1'b0; cpu_clr_we = 1'b0;
        chk(acc_status == m_st, "R10/R11/R12 status", acc_status, m_st);
        chk(wr_err == m_err, "R9 wr_err", wr_err, m_err);
        chk(acc_irq == |(m_st & m_en), "R13 irq", acc_irq, |(m_st & m_en));
    endtask

    // op 0 enable, 1 set, 2 clear
    task automatic cpu_op(input int op, input logic [31:0] d);
        @(negedge clk);
        cpu_wdata = d;
        cpu_en_we = (op == 0); cpu_set_we = (op == 1); cpu_clr_we = (op == 2);
        @(negedge clk);
        cpu_en_we = 1'b0; cpu_set_we = 1'b0; cpu_clr_we = 1'b0;
        if (op == 0) m_en = d;
        if (op == 1) m_st = m_st | d;
        if (op == 2) m_st = m_st & ~d;
        chk(acc_enable == m_en, "R13 enable", acc_enable, m_en);
        chk(acc_status == m_st, "R12 status", acc_status, m_st);
        chk(acc_irq == |(m_st & m_en), "R13 irq", acc_irq, |(m_st & m_en));
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; err_clr = 0;
        cpu_wdata = 0; cpu_en_we = 0; cpu_set_we = 0; cpu_clr_we = 0;
        ro_base = 9'h60; fifo_base = 9'h70; ram_base = 9'h0A0;
        m_st = 0; m_en = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({lram_we, lram_re, fifo_pop, wr_err, acc_irq} == 5'b0, "R1 strobes/flags",
            {lram_we, lram_re, fifo_pop, wr_err, acc_irq}, 0);
        chk(acc_enable == 0 && acc_status == 0, "R1 registers", {acc_enable, acc_status}, 0);

        // R7 legality corners
        set_cfg(9'h78, 9'h78, 9'h100);
        set_cfg(9'h80, 9'h80, 9'h100);
        set_cfg(9'h08, 9'h04, 9'h100);
        set_cfg(9'h40, 9'h30, 9'h100);
        set_cfg(9'h10, 9'h20, 9'h108);
        set_cfg(9'h60, 9'h70, 9'h0A0);

        cpu_op(0, 32'hFFFF_FFFF);
        access(1, 0, 8'h00, 8'hA5, 0, 0);   // R10 first byte bit
        access(1, 0, 8'h0F, 8'h11, 0, 0);   // R10 last byte bit
        access(1, 0, 8'h13, 8'h22, 0, 0);   // R11 first group
        access(1, 0, 8'h12, 8'h33, 0, 0);   // R11 non-last byte
        access(1, 0, 8'h4F, 8'h44, 0, 0);   // R11 last group
        access(1, 0, 8'h53, 8'h55, 0, 0);   // R11 above map
        access(0, 1, 8'h20, 8'h00, 0, 0);   // R3 direct read
        access(1, 0, 8'h65, 8'h66, 0, 0);   // R4 read-only write
        access(0, 1, 8'h65, 8'h00, 0, 0);   // R3 read-only read
        access(0, 1, 8'h7F, 8'h00, 1, 0);   // R5 pop, R9 clear
        access(1, 0, 8'h7F, 8'h77, 0, 0);   // R5 write refused
        access(1, 0, 8'h90, 8'h01, 1, 0);   // R9 refusal with clear
        access(0, 1, 8'h75, 8'h00, 1, 0);   // R6 window read
        access(0, 1, 8'hB0, 8'h00, 0, 0);   // R6 private read
        access(1, 1, 8'h05, 8'h5A, 0, 0);   // R14 write wins
        access(1, 0, 8'h05, 8'h5B, 0, 32'h0400_0000); // R12 hit beats clear
        cpu_op(2, 32'hFFFF_FFFF);
        cpu_op(1, 32'h0000_8001);
        cpu_op(0, 32'h0000_0001);
        cpu_op(0, 32'h0);
        set_cfg(9'h70, 9'h60, 9'h100);
        access(1, 0, 8'h05, 8'h01, 1, 0);   // R8 invalid write
        access(0, 1, 8'h7F, 8'h00, 1, 0);   // R8 invalid pop

        for (int n = 0; n < 400; n++) begin
            if (n % 20 == 0) begin
                logic [8:0] r, f, m;
                r = 9'(8 * $urandom_range(0, 15));
                f = r + 9'(8 * $urandom_range(0, (120 - int'(r)) / 8));
                m = f + 9'(8 * $urandom_range(0, (256 - int'(f)) / 8));
                if ($urandom_range(0, 4) == 0) m = 9'($urandom_range(0, 511));
                set_cfg(r, f, m);
            end
            if ($urandom_range(0, 7) == 0)
                cpu_op(int'($urandom_range(0, 2)), $urandom);
            else
                access($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                       ($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 8'h4F)) : 8'($urandom),
                       8'($urandom), $urandom_range(0, 7) == 0,
                       ($urandom_range(0, 7) == 0) ? $urandom : 32'h0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule